// File: doc/BRIEF.md
# Serial Controller Status and Register Port

This block is the CPU-facing register file of a serial controller. A byte-wide register port gives access to a mode register, a bit-rate register, a control register, a transmit-data register and a status register. The status register gathers five event flags: data-ready, receive-full, break, transmit-empty and transmit-end. The block also drives the transmit and receive interrupt lines. The serializer, the receive FIFO and the baud generator sit outside. They report their events on single-cycle pulse inputs and take the mode, bit-rate and transmit byte from the outputs.

A status flag clears only when software writes a zero to its bit. A one written to a bit leaves that flag alone. Software can therefore read the status register, clear the flags it has handled, and write the value back without losing a flag that set between the read and the write. A status read while the transmitter is enabled returns the current flags and then sets transmit-empty and transmit-end again. This keeps polling software running while no serializer is attached.

An access is one cycle with `bus_sel` high. A write takes effect at that clock edge. Read data appears on `bus_rdata` from the next edge and holds until the next read.

Top module: `ser_ctl_regs`

## Requirements
- R1: After reset, status reads 0x60, control reads 0x20, bit-rate reads 0xFF, mode reads 0x00, and `irq_rx` and `irq_tx` are low.
- R2: In the status byte, transmit-end is bit 6, transmit-empty is bit 5, break is bit 4, receive-full is bit 1 and data-ready is bit 0. Bits 7, 3 and 2 read 0. Read data is valid on `bus_rdata` one cycle after the read access and holds until the next read.
- R3: A status write clears every flag whose bit is written 0 and keeps every flag whose bit is written 1. A set event in the same cycle as a clear leaves the flag set.
- R4: `irq_rx` rises the cycle after a `rx_full_set` pulse that arrives while control bit 6 is 1. It falls after a status write with bit 1 or bit 0 written 0, or after a control write with bit 6 written 0. A set event in the same cycle as a clear wins. A `rx_full_set` pulse while control bit 6 is 0 leaves `irq_rx` unchanged.
- R5: A write to the transmit-data register (offset 0x0C) clears transmit-empty. It raises `tx_valid` for one cycle after the write, with `tx_data` equal to the written byte. Reads of 0x0C return the last byte written.
- R6: A status read while control bit 5 is 1 returns the flags as they stood before the read, then sets transmit-empty and transmit-end. With control bit 5 at 0, a status read changes no flag.
- R7: A control write with bit 5 written 0 sets transmit-end. `irq_tx` equals the stored control bit 7.
- R8: Mode writes are masked with 0x7B and control writes with 0xFA. `mode_o` presents the stored mode.
- R9: A `brk_pulse` sets the break flag, `rx_ready_set` sets data-ready and `rx_full_set` sets receive-full.
- R10: The mapped offsets are mode 0x00, bit-rate 0x04, control 0x08, transmit-data 0x0C and status 0x10. `rate_o` presents the stored bit-rate. Any other offset reads 0, and writes to it change no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rx_ready_set | input | 1 | Pulse: receive data is available |
| rx_full_set | input | 1 | Pulse: receive FIFO reached its threshold |
| brk_pulse | input | 1 | Pulse: break condition seen on the line |
| tx_valid | output | 1 | One-cycle strobe: new transmit byte |
| tx_data | output | 8 | Transmit byte |
| mode_o | output | 8 | Stored mode register |
| rate_o | output | 8 | Stored bit-rate register |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rx | output | 1 | Receive interrupt line |

## Verification
The bench aims at the corner cases below and states what a faulty design would show in each:
- A flag event in the same cycle as a write-zero clear. A design that lets the clear win drops a received byte's data-ready indication.
- A status read with the transmitter enabled. A design that rearms before capturing never shows transmit-empty low after a transmit-data write.
- A status read with the transmitter disabled. A design that ignores control bit 5 rearms the flags on every poll.
- The receive interrupt. It is driven through both of its clear paths, and through a receive-full pulse while the enable is off. An interrupt tied to the flag, or left ungated, fails these checks.
- Unmapped offsets and the write masks. A loose address decode corrupts the mode or status registers.

// File: rtl/ser_regs_pkg.sv
`timescale 1ns/1ps
package ser_regs_pkg;

   localparam logic [7:0] OFS_MODE = 8'h00;
   localparam logic [7:0] OFS_RATE = 8'h04;
   localparam logic [7:0] OFS_CTRL = 8'h08;
   localparam logic [7:0] OFS_TXD  = 8'h0C;
   localparam logic [7:0] OFS_STAT = 8'h10;

   localparam int FLAG_N = 5;
   localparam int FL_DR  = 0;   // data ready
   localparam int FL_RF  = 1;   // receive full
   localparam int FL_BK  = 2;   // break
   localparam int FL_TE  = 3;   // transmit empty
   localparam int FL_TC  = 4;   // transmit end

   localparam int CTRL_TXIE = 7;
   localparam int CTRL_RXIE = 6;
   localparam int CTRL_TXEN = 5;

   typedef struct packed {
      logic mode;
      logic rate;
      logic ctrl;
      logic txd;
      logic stat;
   } reg_hit_t;

   function automatic int flag_pos(input int idx);
      case (idx)
         FL_DR:   return 0;
         FL_RF:   return 1;
         FL_BK:   return 4;
         FL_TE:   return 5;
         default: return 6;
      endcase
   endfunction

   function automatic logic flag_rst(input int idx);
      return (idx == FL_TE) || (idx == FL_TC);
   endfunction

endpackage

// File: rtl/ser_addr_dec.sv
`timescale 1ns/1ps
module ser_addr_dec
   import ser_regs_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_hit_t          hit
);

   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
   localparam logic [ADDR_W-1:0] A_RATE = ADDR_W'(OFS_RATE);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_TXD  = ADDR_W'(OFS_TXD);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

   if (ADDR_W < 5 || ADDR_W > 16) begin : g_bad_width
      $error("ser_addr_dec: ADDR_W must be within 5..16");
   end

   always_comb begin
      hit      = '0;
      hit.mode = (addr == A_MODE);
      hit.rate = (addr == A_RATE);
      hit.ctrl = (addr == A_CTRL);
      hit.txd  = (addr == A_TXD);
      hit.stat = (addr == A_STAT);
   end

endmodule

// File: rtl/ser_stat_flag.sv
`timescale 1ns/1ps
module ser_stat_flag #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= RST_VAL;
      else if (set_i) q <= 1'b1;
      else if (clr_i) q <= 1'b0;
   end

   // R3: a set event beats a concurrent write-zero
   p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q);

   // R3: a lone write-zero drops the flag
   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q);

endmodule

// File: rtl/ser_rx_irq.sv
`timescale 1ns/1ps
module ser_rx_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic irq_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     irq_o <= 1'b0;
      else if (set_i) irq_o <= 1'b1;
      else if (clr_i) irq_o <= 1'b0;
   end

   p_irq_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> irq_o);

   p_irq_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !irq_o);

endmodule

// File: rtl/ser_ctl_regs.sv
`timescale 1ns/1ps
module ser_ctl_regs
   import ser_regs_pkg::*;
#(
   parameter int         ADDR_W     = 6,
   parameter logic [7:0] MODE_WMASK = 8'h7B,
   parameter logic [7:0] CTRL_WMASK = 8'hFA,
   parameter logic [7:0] CTRL_RST   = 8'h20,
   parameter logic [7:0] RATE_RST   = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              rx_ready_set,
   input  logic              rx_full_set,
   input  logic              brk_pulse,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic [7:0]        mode_o,
   output logic [7:0]        rate_o,
   output logic              irq_tx,
   output logic              irq_rx
);

   localparam logic [7:0] MODE_RST = 8'h00;
   localparam logic [7:0] TXD_RST  = 8'h00;

   if ((CTRL_RST & ~CTRL_WMASK) != 8'h00) begin : g_bad_ctrl_rst
      $error("ser_ctl_regs: CTRL_RST has bits outside CTRL_WMASK");
   end

   reg_hit_t hit;
   logic acc_wr, acc_rd;
   logic wr_mode, wr_rate, wr_ctrl, wr_txd, wr_stat, rd_stat;
   logic [7:0] mode_q, rate_q, ctrl_q, txd_q, rd_mux, stat_img;
   logic txv_q;
   logic rearm;
   logic [FLAG_N-1:0] flag_set, flag_q;
   logic irq_set, irq_clr;

   ser_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .hit  (hit)
   );

   assign acc_wr  = bus_sel &  bus_wr;
   assign acc_rd  = bus_sel & ~bus_wr;
   assign wr_mode = acc_wr & hit.mode;
   assign wr_rate = acc_wr & hit.rate;
   assign wr_ctrl = acc_wr & hit.ctrl;
   assign wr_txd  = acc_wr & hit.txd;
   assign wr_stat = acc_wr & hit.stat;
   assign rd_stat = acc_rd & hit.stat;
   assign rearm   = rd_stat & ctrl_q[CTRL_TXEN];

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RST;
         rate_q <= RATE_RST;
         ctrl_q <= CTRL_RST;
         txd_q  <= TXD_RST;
         txv_q  <= 1'b0;
      end else begin
         txv_q <= wr_txd;
         if (wr_mode) mode_q <= bus_wdata & MODE_WMASK;
         if (wr_rate) rate_q <= bus_wdata;
         if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_WMASK;
         if (wr_txd)  txd_q  <= bus_wdata;
      end
   end

   // flag set sources
   always_comb begin
      flag_set        = '0;
      flag_set[FL_DR] = rx_ready_set;
      flag_set[FL_RF] = rx_full_set;
      flag_set[FL_BK] = brk_pulse;
      flag_set[FL_TE] = rearm;
      flag_set[FL_TC] = rearm | (wr_ctrl & ~bus_wdata[CTRL_TXEN]);
   end

   for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
      localparam int POS = flag_pos(g);
      logic clr_w;
      if (g == FL_TE) begin : g_txd_clr
         assign clr_w = (wr_stat & ~bus_wdata[POS]) | wr_txd;
      end else begin : g_plain_clr
         assign clr_w = wr_stat & ~bus_wdata[POS];
      end
      ser_stat_flag #(.RST_VAL(flag_rst(g))) u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (flag_set[g]),
         .clr_i (clr_w),
         .q     (flag_q[g])
      );
   end

   always_comb begin
      stat_img = '0;
      for (int i = 0; i < FLAG_N; i++) stat_img[flag_pos(i)] = flag_q[i];
   end

   // receive interrupt
   assign irq_set = rx_full_set & ctrl_q[CTRL_RXIE];
   assign irq_clr = (wr_stat & (~bus_wdata[flag_pos(FL_RF)] | ~bus_wdata[flag_pos(FL_DR)]))
                  | (wr_ctrl & ~bus_wdata[CTRL_RXIE]);

   ser_rx_irq u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (irq_set),
      .clr_i (irq_clr),
      .irq_o (irq_rx)
   );

   // read path, captured before this edge's flag updates
   always_comb begin
      rd_mux = '0;
      unique case (1'b1)
         hit.mode: rd_mux = mode_q;
         hit.rate: rd_mux = rate_q;
         hit.ctrl: rd_mux = ctrl_q;
         hit.txd:  rd_mux = txd_q;
         hit.stat: rd_mux = stat_img;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (acc_rd) bus_rdata <= rd_mux;
   end

   assign tx_valid = txv_q;
   assign tx_data  = txd_q;
   assign mode_o   = mode_q;
   assign rate_o   = rate_q;
   assign irq_tx   = ctrl_q[CTRL_TXIE];

   p_hit_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));

   p_stat_spare_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stat |=> ((bus_rdata & 8'h8C) == 8'h00));

   p_tx_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_txd |=> (tx_valid && tx_data == $past(bus_wdata)));

   p_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && ctrl_q[CTRL_TXEN]) |=> (stat_img[6:5] == 2'b11));

   p_tend_on_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !bus_wdata[CTRL_TXEN]) |=> stat_img[6]);

   p_ctrl_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> ((ctrl_q & ~CTRL_WMASK) == 8'h00));

endmodule

// File: tb/ser_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module ser_ctl_regs_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0;
   logic [5:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       rx_ready_set = 1'b0, rx_full_set = 1'b0, brk_pulse = 1'b0;
   wire  [7:0] bus_rdata, tx_data, mode_o, rate_o;
   wire        tx_valid, irq_tx, irq_rx;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   ser_ctl_regs dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_ready_set(rx_ready_set), .rx_full_set(rx_full_set), .brk_pulse(brk_pulse),
      .tx_valid(tx_valid), .tx_data(tx_data), .mode_o(mode_o), .rate_o(rate_o),
      .irq_tx(irq_tx), .irq_rx(irq_rx)
   );

   // ---------------- behavioural reference ----------------
   logic [7:0] m_mode, m_rate, m_ctrl, m_txd, m_stat, m_rd;
   logic       m_irq, m_txv;
   logic [7:0] nx;
   logic       irqc;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode <= 8'h00; m_rate <= 8'hFF; m_ctrl <= 8'h20; m_txd <= 8'h00;
         m_stat <= 8'h60; m_rd <= 8'h00; m_irq <= 1'b0; m_txv <= 1'b0;
      end else begin
         nx   = m_stat;
         irqc = 1'b0;
         m_txv <= 1'b0;
         if (bus_sel && bus_wr) begin
            case (bus_addr)
               6'h00: m_mode <= bus_wdata & 8'h7B;
               6'h04: m_rate <= bus_wdata;
               6'h08: begin
                  m_ctrl <= bus_wdata & 8'hFA;
                  if (!bus_wdata[5]) nx[6] = 1'b1;
                  if (!bus_wdata[6]) irqc = 1'b1;
               end
               6'h0C: begin m_txd <= bus_wdata; m_txv <= 1'b1; nx[5] = 1'b0; end
               6'h10: begin
                  nx = nx & bus_wdata;
                  if (!bus_wdata[1] || !bus_wdata[0]) irqc = 1'b1;
               end
               default: ;
            endcase
         end else if (bus_sel) begin
            case (bus_addr)
               6'h00: m_rd <= m_mode;
               6'h04: m_rd <= m_rate;
               6'h08: m_rd <= m_ctrl;
               6'h0C: m_rd <= m_txd;
               6'h10: m_rd <= m_stat;
               default: m_rd <= 8'h00;
            endcase
            if (bus_addr == 6'h10 && m_ctrl[5]) nx = nx | 8'h60;
         end
         if (brk_pulse)    nx[4] = 1'b1;
         if (rx_full_set)  nx[1] = 1'b1;
         if (rx_ready_set) nx[0] = 1'b1;
         m_stat <= nx;
         if (rx_full_set && m_ctrl[6]) m_irq <= 1'b1;
         else if (irqc)                m_irq <= 1'b0;
      end
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual 0x%02h expected 0x%02h", tag, $time, act, exp);
      end
   endtask

   // per-cycle comparison against the reference
   always @(posedge clk) begin
      #2;
      if (!done) begin
         chk("R2 rdata",    bus_rdata,       m_rd);
         chk("R4 irq_rx",   {7'd0, irq_rx},  {7'd0, m_irq});
         chk("R7 irq_tx",   {7'd0, irq_tx},  {7'd0, m_ctrl[7]});
         chk("R5 tx_valid", {7'd0, tx_valid},{7'd0, m_txv});
         chk("R5 tx_data",  tx_data,         m_txd);
         chk("R8 mode_o",   mode_o,          m_mode);
         chk("R10 rate_o",  rate_o,          m_rate);
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic wr(input logic [5:0] a, input logic [7:0] d, input logic [2:0] ev);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      {brk_pulse, rx_full_set, rx_ready_set} = ev;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      {brk_pulse, rx_full_set, rx_ready_set} = 3'b000;
   endtask

   task automatic ev(input logic [2:0] e);
      @(negedge clk);
      {brk_pulse, rx_full_set, rx_ready_set} = e;
      @(negedge clk);
      {brk_pulse, rx_full_set, rx_ready_set} = 3'b000;
   endtask

   task automatic rd(input logic [5:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      chk(tag, bus_rdata, exp);
   endtask

   // ---------------- directed and random sequence ----------------
   initial begin
      logic [5:0] addrs [8] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h10, 6'h14, 6'h3C};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      rd(6'h10, 8'h60, "R1 status");
      rd(6'h08, 8'h20, "R1 control");
      rd(6'h04, 8'hFF, "R1 rate");
      rd(6'h00, 8'h00, "R1 mode");
      chk("R1 irq_rx", {7'd0, irq_rx}, 8'h00);
      chk("R1 irq_tx", {7'd0, irq_tx}, 8'h00);

      wr(6'h00, 8'hFF, 3'b000);
      rd(6'h00, 8'h7B, "R8 mode mask");
      wr(6'h08, 8'hFF, 3'b000);
      rd(6'h08, 8'hFA, "R8 control mask");
      chk("R7 irq_tx high", {7'd0, irq_tx}, 8'h01);

      ev(3'b100);
      ev(3'b001);
      ev(3'b010);
      chk("R4 irq_rx set", {7'd0, irq_rx}, 8'h01);
      rd(6'h10, 8'h73, "R9 flags set");

      wr(6'h10, 8'hFF, 3'b000);
      rd(6'h10, 8'h73, "R3 write-one keeps");
      wr(6'h10, 8'hEF, 3'b000);
      rd(6'h10, 8'h63, "R3 break cleared");
      chk("R4 irq_rx kept", {7'd0, irq_rx}, 8'h01);
      wr(6'h10, 8'hFD, 3'b000);
      chk("R4 irq_rx cleared by status", {7'd0, irq_rx}, 8'h00);
      rd(6'h10, 8'h61, "R3 receive-full cleared");
      wr(6'h10, 8'hFE, 3'b001);
      rd(6'h10, 8'h61, "R3 set wins over clear");

      wr(6'h0C, 8'hA5, 3'b000);
      chk("R5 tx_valid", {7'd0, tx_valid}, 8'h01);
      chk("R5 tx_data", tx_data, 8'hA5);
      rd(6'h10, 8'h41, "R5 transmit-empty cleared");
      rd(6'h10, 8'h61, "R6 rearm after read");
      rd(6'h0C, 8'hA5, "R5 readback");

      wr(6'h08, 8'h40, 3'b000);
      chk("R7 irq_tx low", {7'd0, irq_tx}, 8'h00);
      wr(6'h10, 8'h9F, 3'b000);
      rd(6'h10, 8'h01, "R6 no rearm capture");
      rd(6'h10, 8'h01, "R6 no rearm when disabled");
      wr(6'h08, 8'h40, 3'b000);
      rd(6'h10, 8'h41, "R7 transmit-end set");

      ev(3'b010);
      chk("R4 irq_rx set again", {7'd0, irq_rx}, 8'h01);
      rd(6'h10, 8'h43, "R9 receive-full");
      wr(6'h08, 8'h00, 3'b000);
      chk("R4 irq_rx cleared by control", {7'd0, irq_rx}, 8'h00);
      ev(3'b010);
      chk("R4 irq_rx gated", {7'd0, irq_rx}, 8'h00);

      wr(6'h14, 8'hFF, 3'b000);
      wr(6'h3C, 8'h55, 3'b000);
      rd(6'h14, 8'h00, "R10 unmapped 0x14");
      rd(6'h3C, 8'h00, "R10 unmapped 0x3C");
      rd(6'h00, 8'h7B, "R10 mode untouched");
      rd(6'h08, 8'h00, "R10 control untouched");
      rd(6'h04, 8'hFF, "R10 rate untouched");
      rd(6'h0C, 8'hA5, "R10 tx data untouched");
      rd(6'h10, 8'h43, "R10 status untouched");
      wr(6'h04, 8'h33, 3'b000);
      rd(6'h04, 8'h33, "R10 rate write");

      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         bus_sel      = ($urandom_range(0, 1) == 1);
         bus_wr       = ($urandom_range(0, 2) == 0);
         bus_addr     = addrs[$urandom_range(0, 7)];
         bus_wdata    = 8'($urandom);
         brk_pulse    = ($urandom_range(0, 7) == 0);
         rx_full_set  = ($urandom_range(0, 7) == 0);
         rx_ready_set = ($urandom_range(0, 7) == 0);
      end
      @(negedge clk);
      bus_sel = 1'b0;
      {brk_pulse, rx_full_set, rx_ready_set} = 3'b000;
      repeat (3) @(negedge clk);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule